// File: doc/BRIEF.md
# Approximate 8-Point DCT with Selectable Output Count

This block computes one pass of an eight-point discrete cosine transform for image compression without using any multiplier. Eight signed, level-shifted pixel samples arrive together with a valid strobe and a two-bit mode. Two clock cycles later, eight signed coefficients come out. The transform is unnormalized: each cosine constant is scaled by 64, and the weighted sum is shifted right by six bits. Any further scaling is left to downstream logic.

The first stage is an even/odd butterfly. A second stage then multiplies the butterfly terms by constants, with each constant written as a short sum of signed powers of two. Outputs 0 to 3 carry most of the picture energy, so they use a finer constant set. Outputs 4 to 7 use a coarser set with at most two nonzero digits per constant. The mode selects how many high-frequency outputs are dropped. A dropped output has its operands ANDed to zero before its adder tree, so that tree stays quiet and the output reads zero. Accuracy falls step by step as more outputs are dropped.

Top module: `approx_dct8`

## Requirements
- R1: A synchronous active-high `rst` clears every pipeline register. While reset is applied, `out_valid` is 0 and `out_y` is all zeros.
- R2: `out_valid` equals `in_valid` delayed by exactly two clock edges. A result sampled at edge k appears on `out_y` after edge k+1.
- R3: Sample i is `in_x[9i+8:9i]` and coefficient k is `out_y[13k+12:13k]`, both two's complement. With s_i = x_i + x_{7-i}, d_i = x_i - x_{7-i}, e0 = s0+s3, e1 = s1+s2, f0 = s0-s3 and f1 = s1-s2, the low-frequency sums are:
  - Y0 = 45(e0+e1)
  - Y1 = 63d0+53d1+36d2+12d3
  - Y2 = 59f0+24f1
  - Y3 = 53d0-12d1-63d2-36d3
- R4: The high-frequency sums use the coarse constants:
  - Y4 = 48(e0-e1)
  - Y5 = 36d0-64d1+12d2+56d3
  - Y6 = 24f0-60f1
  - Y7 = 12d0-36d1+56d2-64d3
- R5: Each output is its sum Yk arithmetically shifted right by 6 bits (rounding toward minus infinity), with no overflow for any 9-bit input.
- R6: Mode 2'b00 delivers all eight coefficients.
- R7: Mode 2'b01 forces output 7 to zero and leaves outputs 0 to 6 unchanged.
- R8: Mode 2'b10 forces outputs 6 and 7 to zero.
- R9: Mode 2'b11 forces outputs 4 to 7 to zero and keeps outputs 0 to 3.
- R10: The mode is captured together with the sample set. A mode change on a cycle where `in_valid` is low does not affect the pending result.
- R11: When a cycle's input was not valid, `out_y` keeps the previous result, whatever `in_x` and `in_mode` carried.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample set valid |
| in_mode | input | 2 | Output-drop mode (00 all, 01 drop 7, 10 drop 6-7, 11 drop 4-7) |
| in_x | input | 72 | Eight 9-bit signed samples, sample i at bits 9i+8:9i |
| out_valid | output | 1 | Coefficient set valid |
| out_y | output | 104 | Eight 13-bit signed coefficients, index k at bits 13k+12:13k |

## Verification
The bench drives sample sets that reach the extremes of each sum: all samples at +255 or at -256, alternating signs, and a half-positive/half-negative pattern that maximizes the odd terms. A design whose internal sums are too narrow would wrap these into wrong signs. Negative sums that are not multiples of 64 expose a truncating shift, which would come out one above the floor. Dropped outputs are checked in each mode, including a mode change on an idle cycle, which would wrongly zero a pending result if the mode were not captured with the data. Idle cycles carry random inputs, so a pipeline that reloaded without a valid strobe would show new values where the last result should be held.

// File: rtl/approx_dct8.sv
module approx_dct8 #(
  parameter int IW = 9,
  parameter int OW = 13,
  parameter int FB = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [1:0]      in_mode,
  input  logic [8*IW-1:0] in_x,
  output logic            out_valid,
  output logic [8*OW-1:0] out_y
);
  localparam int N  = 8;
  localparam int H  = N / 2;
  localparam int SW = IW + 1;
  localparam int EW = IW + 2;
  localparam int AW = IW + FB + 6;

  typedef logic signed [AW-1:0] acc_t;

  // fine constants, low-frequency outputs
  function automatic acc_t m63(input acc_t v); return (v <<< 6) - v; endfunction
  function automatic acc_t m59(input acc_t v); return (v <<< 6) - (v <<< 2) - v; endfunction
  function automatic acc_t m53(input acc_t v); return (v <<< 6) - (v <<< 4) + (v <<< 2) + v; endfunction
  function automatic acc_t m45(input acc_t v); return (v <<< 6) - (v <<< 4) - (v <<< 2) + v; endfunction
  // shared by both sets
  function automatic acc_t m36(input acc_t v); return (v <<< 5) + (v <<< 2); endfunction
  function automatic acc_t m24(input acc_t v); return (v <<< 5) - (v <<< 3); endfunction
  function automatic acc_t m12(input acc_t v); return (v <<< 4) - (v <<< 2); endfunction
  // coarse constants, high-frequency outputs
  function automatic acc_t m64(input acc_t v); return v <<< 6; endfunction
  function automatic acc_t m60(input acc_t v); return (v <<< 6) - (v <<< 2); endfunction
  function automatic acc_t m56(input acc_t v); return (v <<< 6) - (v <<< 3); endfunction
  function automatic acc_t m48(input acc_t v); return (v <<< 6) - (v <<< 4); endfunction

  logic signed [IW-1:0] x [N];
  logic signed [SW-1:0] s [H];
  logic signed [SW-1:0] d [H];

  for (genvar i = 0; i < N; i++) begin : g_in
    assign x[i] = in_x[i*IW +: IW];
  end

  for (genvar i = 0; i < H; i++) begin : g_bfly
    assign s[i] = SW'(x[i]) + SW'(x[N-1-i]);
    assign d[i] = SW'(x[i]) - SW'(x[N-1-i]);
  end

  logic                 v1_q;
  logic [1:0]           mode_q;
  logic signed [EW-1:0] e0_q, e1_q, f0_q, f1_q;
  logic signed [SW-1:0] d_q [H];

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q   <= 1'b0;
      mode_q <= '0;
      e0_q   <= '0;
      e1_q   <= '0;
      f0_q   <= '0;
      f1_q   <= '0;
      for (int i = 0; i < H; i++) d_q[i] <= '0;
    end else begin
      v1_q <= in_valid;
      if (in_valid) begin
        mode_q <= in_mode;
        e0_q   <= EW'(s[0]) + EW'(s[3]);
        e1_q   <= EW'(s[1]) + EW'(s[2]);
        f0_q   <= EW'(s[0]) - EW'(s[3]);
        f1_q   <= EW'(s[1]) - EW'(s[2]);
        for (int i = 0; i < H; i++) d_q[i] <= d[i];
      end
    end
  end

  logic k4, k6, k7;
  assign k4 = (mode_q != 2'b11);
  assign k6 = ~mode_q[1];
  assign k7 = (mode_q == 2'b00);

  acc_t ea, eb, fa, fb, ea4, eb4, fa6, fb6;
  acc_t dw [H];
  acc_t d5 [H];
  acc_t d7 [H];

  assign ea  = AW'(e0_q);
  assign eb  = AW'(e1_q);
  assign fa  = AW'(f0_q);
  assign fb  = AW'(f1_q);
  assign ea4 = ea & {AW{k4}};
  assign eb4 = eb & {AW{k4}};
  assign fa6 = fa & {AW{k6}};
  assign fb6 = fb & {AW{k6}};

  for (genvar i = 0; i < H; i++) begin : g_gate
    assign dw[i] = AW'(d_q[i]);
    assign d5[i] = dw[i] & {AW{k4}};
    assign d7[i] = dw[i] & {AW{k7}};
  end

  acc_t y [N];
  assign y[0] = m45(ea + eb);
  assign y[1] = m63(dw[0]) + m53(dw[1]) + m36(dw[2]) + m12(dw[3]);
  assign y[2] = m59(fa) + m24(fb);
  assign y[3] = m53(dw[0]) - m12(dw[1]) - m63(dw[2]) - m36(dw[3]);
  assign y[4] = m48(ea4 - eb4);
  assign y[5] = m36(d5[0]) - m64(d5[1]) + m12(d5[2]) + m56(d5[3]);
  assign y[6] = m24(fa6) - m60(fb6);
  assign y[7] = m12(d7[0]) - m36(d7[1]) + m56(d7[2]) - m64(d7[3]);

  logic          v2_q;
  logic [OW-1:0] y_q [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      v2_q <= 1'b0;
      for (int k = 0; k < N; k++) y_q[k] <= '0;
    end else begin
      v2_q <= v1_q;
      if (v1_q)
        for (int k = 0; k < N; k++) y_q[k] <= OW'(y[k] >>> FB);
    end
  end

  assign out_valid = v2_q;
  for (genvar k = 0; k < N; k++) begin : g_out
    assign out_y[k*OW +: OW] = y_q[k];
  end
endmodule

module approx_dct8_chk #(
  parameter int OW = 13
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [1:0]      in_mode,
  input logic            out_valid,
  input logic [8*OW-1:0] out_y
);
  logic [1:0] cnt;
  logic       rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) cnt <= '0;
    else if (cnt != 2'd2) cnt <= cnt + 2'd1;
  end

  always @(posedge clk)
    if (rst_q) p_reset_clear_r1: assert (!out_valid && out_y == '0);

  p_valid_delay_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt == 2'd2) |-> (out_valid == $past(in_valid, 2)));

  p_drop_one_r7: assert property (@(posedge clk) disable iff (rst)
    (cnt == 2'd2 && out_valid && $past(in_mode, 2) == 2'b01) |-> (out_y[7*OW +: OW] == '0));

  p_drop_two_r8: assert property (@(posedge clk) disable iff (rst)
    (cnt == 2'd2 && out_valid && $past(in_mode, 2) == 2'b10) |-> (out_y[6*OW +: 2*OW] == '0));

  p_drop_four_r9: assert property (@(posedge clk) disable iff (rst)
    (cnt == 2'd2 && out_valid && $past(in_mode, 2) == 2'b11) |-> (out_y[4*OW +: 4*OW] == '0));

  p_hold_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (cnt == 2'd2 && !$past(in_valid, 2)) |-> $stable(out_y));
endmodule

bind approx_dct8 approx_dct8_chk #(.OW(OW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
  .out_valid(out_valid), .out_y(out_y)
);

// File: tb/test_approx_dct8.sv
module test_approx_dct8;
  localparam int IW = 9;
  localparam int OW = 13;
  localparam int TP = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic [1:0]      in_mode = '0;
  logic [8*IW-1:0] in_x = '0;
  logic            out_valid;
  logic [8*OW-1:0] out_y;

  always #(TP/2) clk = ~clk;

  approx_dct8 i_approx_dct8 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
    .in_x(in_x), .out_valid(out_valid), .out_y(out_y)
  );

  typedef struct {
    bit              v;
    int              md;
    logic [8*OW-1:0] y;
    time             t;
  } item_t;

  item_t           sb[$];
  logic [8*OW-1:0] last_y = '0;
  int              errors = 0;
  int              checks = 0;
  int unsigned     seed = 32'h1234_5678;

  // R5: weighted sums scaled by 64, floor shift by 6
  function automatic logic [8*OW-1:0] model(input int xv[8], input int md);
    int s[4], d[4], e0, e1, f0, f1;
    int yy[8];
    logic [8*OW-1:0] r;
    for (int i = 0; i < 4; i++) begin
      s[i] = xv[i] + xv[7-i];
      d[i] = xv[i] - xv[7-i];
    end
    e0 = s[0] + s[3]; e1 = s[1] + s[2];
    f0 = s[0] - s[3]; f1 = s[1] - s[2];
    yy[0] = 45 * (e0 + e1);
    yy[1] = 63*d[0] + 53*d[1] + 36*d[2] + 12*d[3];
    yy[2] = 59*f0 + 24*f1;
    yy[3] = 53*d[0] - 12*d[1] - 63*d[2] - 36*d[3];
    yy[4] = 48 * (e0 - e1);
    yy[5] = 36*d[0] - 64*d[1] + 12*d[2] + 56*d[3];
    yy[6] = 24*f0 - 60*f1;
    yy[7] = 12*d[0] - 36*d[1] + 56*d[2] - 64*d[3];
    for (int k = 0; k < 8; k++) begin
      int q;
      q = yy[k] >>> 6;
      if ((md == 1 && k == 7) || (md == 2 && k >= 6) || (md == 3 && k >= 4)) q = 0;
      r[k*OW +: OW] = q[OW-1:0];
    end
    return r;
  endfunction

  function automatic string tag(input bit v, input int md, input int k);
    if (!v) return "R11";
    if (md == 1 && k == 7) return "R7";
    if (md == 2 && k >= 6) return "R8";
    if (md == 3 && k >= 4) return "R9";
    if (md == 0) return (k < 4) ? "R3/R6" : "R4/R6";
    return (k < 4) ? "R3" : "R4";
  endfunction

  task automatic drive(input bit v, input int md, input int xv[8]);
    item_t it;
    @(negedge clk);
    in_valid = v;
    in_mode  = md[1:0];
    for (int i = 0; i < 8; i++) in_x[i*IW +: IW] = xv[i][IW-1:0];
    if (v) last_y = model(xv, md);
    it.v = v; it.md = md; it.y = last_y; it.t = $time;
    sb.push_back(it);
  endtask

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) % 512) - 256;
  endfunction

  task automatic drive_rand(input bit v, input int md);
    int xv[8];
    for (int i = 0; i < 8; i++) xv[i] = rnd();
    drive(v, md, xv);
  endtask

  // monitor: result of an item driven at time t is visible after t + TP/2 + TP
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (sb.size() > 0 && $time - sb[0].t >= TP/2 + TP + 2) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (out_valid !== it.v) begin
          errors++;
          $display("FAIL R2 out_valid actual=%b expected=%b", out_valid, it.v);
        end
        for (int k = 0; k < 8; k++) begin
          checks++;
          if (out_y[k*OW +: OW] !== it.y[k*OW +: OW]) begin
            errors++;
            $display("FAIL %s out_y[%0d] mode=%0d actual=%0d expected=%0d", tag(it.v, it.md, k), k,
                     it.md, $signed(out_y[k*OW +: OW]), $signed(it.y[k*OW +: OW]));
          end
        end
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    int xv[8];
    // R1: reset holds outputs clear even with valid input present
    in_valid = 1'b1;
    for (int i = 0; i < 8; i++) in_x[i*IW +: IW] = 9'h0FF;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_y !== '0) begin
      errors++;
      $display("FAIL R1 reset actual=%b/%h expected=0/0", out_valid, out_y);
    end
    in_valid = 1'b0;
    rst = 1'b0;

    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < 8; i++) xv[i] = 0;         drive(1, m, xv);
      for (int i = 0; i < 8; i++) xv[i] = 255;       drive(1, m, xv);
      for (int i = 0; i < 8; i++) xv[i] = -256;      drive(1, m, xv);
      for (int i = 0; i < 8; i++) xv[i] = (i % 2) ? -256 : 255; drive(1, m, xv);
      for (int i = 0; i < 8; i++) xv[i] = (i < 4) ? 255 : -256; drive(1, m, xv);
      for (int i = 0; i < 8; i++) xv[i] = (i < 4) ? -256 : 255; drive(1, m, xv);
      for (int i = 0; i < 8; i++) xv[i] = i * 37 - 129; drive(1, m, xv);
      for (int p = 0; p < 8; p++) begin
        for (int i = 0; i < 8; i++) xv[i] = (i == p) ? -1 : 0;
        drive(1, m, xv);
      end
    end

    // R10: a valid set in M3 followed by an idle cycle that shows mode 00
    for (int i = 0; i < 8; i++) xv[i] = 200 - 50 * i;
    drive(1, 3, xv);
    drive(0, 0, xv);
    drive(0, 0, xv);
    drive(1, 1, xv);
    drive_rand(0, 3);

    // R11 and all modes: random sets with random idle gaps
    for (int n = 0; n < 300; n++) begin
      int md;
      md = (rnd() + 256) % 4;
      drive_rand(((rnd() + 256) % 3) != 0, md);
    end

    repeat (4) @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule